// File: doc/BRIEF.md
# Coprocessor Result Readout Front End

This block is the register face of a math coprocessor. A host bus reaches three word registers through it: a control/status word, a write-only argument port and a read-only result port. The compute core sits outside the block. It takes arguments from a one-cycle strobe and hands back up to two 32-bit results with a one-cycle valid pulse.

The result port is sequenced. What one read returns, and whether that read finishes the transfer, depends on the result-size and result-count fields of the control word. A ready flag is set when results are posted and cleared by the read that ends the sequence. The flag also drives an interrupt line and a DMA read request, each gated by its own enable bit.

Top module: `cop_result_frontend`

## Requirements
- R1: Registers are decoded by byte address on word boundaries: control/status at 0x0, argument at 0x4, result at 0x8. Any other address, including a misaligned one, reads as 0 and ignores writes. The argument register reads as 0.
- R2: The control/status word has the ready flag at bit 31, argument size at bit 22, result size at bit 21, argument count at bit 20, result count at bit 19, DMA write enable at bit 18, DMA read enable at bit 17, interrupt enable at bit 16, scale at bits 10:8, precision at bits 7:4 and function at bits 3:0. It resets to 0x00000050. Reserved bits read as 0.
- R3: Writes to the ready flag and to reserved bits have no effect. All other fields take the written value.
- R4: A result-valid pulse loads both results, sets the ready flag and returns the read pointer to the primary result. It takes priority over a result read in the same cycle.
- R5: With result size 0 and result count 1, the first result read returns the primary result and leaves ready set. The second read returns the secondary result and clears ready.
- R6: With result size 0 and result count 0, one read returns the primary result and clears ready.
- R7: With result size 1, one read returns the primary result's low half in bits 15:0 and the secondary result's low half in bits 31:16, then clears ready, whatever the result count.
- R8: A result read while ready is clear returns the value of the last read that completed with ready set (0 after reset). It changes no state.
- R9: The result register is read-only; writes to it change neither the ready flag nor the sequence.
- R10: An argument write raises arg_valid_o for exactly one cycle, the cycle after the write, with the written word on arg_data_o.
- R11: irq_o is the ready flag ANDed with interrupt enable. dma_rd_req_o is the ready flag ANDed with DMA read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| res_valid_i | input | 1 | One-cycle pulse: core posts results |
| res_primary_i | input | 32 | First result |
| res_secondary_i | input | 32 | Second result |
| arg_valid_o | output | 1 | One-cycle argument strobe |
| arg_data_o | output | 32 | Argument word |
| irq_o | output | 1 | Interrupt request |
| dma_rd_req_o | output | 1 | DMA read request |

## Verification
The bench sweeps both result sizes against both result counts over several data patterns. In each case it reads the result port until ready drops, then once more. A design that ignored the count would clear ready after the first of two reads, and one that ignored the size would return a whole word instead of the packed halves. The extra read catches a design that advances the pointer while idle or returns fresh data instead of the held value. A second post in the middle of a two-read sequence must restart at the primary result; a design that did not reset the pointer would return the stale secondary. Writing all ones and all zeros to the control word catches a writable ready flag or reserved bits that read back as 1.

// File: rtl/cop_fe_pkg.sv
package cop_fe_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;

  localparam int unsigned RDY_BIT   = 31;
  localparam int unsigned ASZ_BIT   = 22;
  localparam int unsigned RSZ_BIT   = 21;
  localparam int unsigned NARG_BIT  = 20;
  localparam int unsigned NRES_BIT  = 19;
  localparam int unsigned DMAW_BIT  = 18;
  localparam int unsigned DMAR_BIT  = 17;
  localparam int unsigned IEN_BIT   = 16;
  localparam int unsigned SCALE_LSB = 8;
  localparam int unsigned SCALE_W   = 3;
  localparam int unsigned PREC_LSB  = 4;
  localparam int unsigned PREC_W    = 4;
  localparam int unsigned FUNC_LSB  = 0;
  localparam int unsigned FUNC_W    = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ARG  = 2'd1,
    SEL_RES  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic               arg_size;
    logic               res_size;
    logic               nargs;
    logic               nres;
    logic               dma_wr_en;
    logic               dma_rd_en;
    logic               irq_en;
    logic [SCALE_W-1:0] scale;
    logic [PREC_W-1:0]  precision;
    logic [FUNC_W-1:0]  func;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = ctrl_t'(18'h00050);

  function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c, logic rdy);
    logic [DATA_W-1:0] w;
    w = '0;
    w[RDY_BIT]  = rdy;
    w[ASZ_BIT]  = c.arg_size;
    w[RSZ_BIT]  = c.res_size;
    w[NARG_BIT] = c.nargs;
    w[NRES_BIT] = c.nres;
    w[DMAW_BIT] = c.dma_wr_en;
    w[DMAR_BIT] = c.dma_rd_en;
    w[IEN_BIT]  = c.irq_en;
    w[SCALE_LSB +: SCALE_W] = c.scale;
    w[PREC_LSB +: PREC_W]   = c.precision;
    w[FUNC_LSB +: FUNC_W]   = c.func;
    return w;
  endfunction

  function automatic ctrl_t unpack_ctrl(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.arg_size  = w[ASZ_BIT];
    c.res_size  = w[RSZ_BIT];
    c.nargs     = w[NARG_BIT];
    c.nres      = w[NRES_BIT];
    c.dma_wr_en = w[DMAW_BIT];
    c.dma_rd_en = w[DMAR_BIT];
    c.irq_en    = w[IEN_BIT];
    c.scale     = w[SCALE_LSB +: SCALE_W];
    c.precision = w[PREC_LSB +: PREC_W];
    c.func      = w[FUNC_LSB +: FUNC_W];
    return c;
  endfunction
endpackage

// File: rtl/cop_fe_decode.sv
module cop_fe_decode
  import cop_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_ctrl_o,
  output logic              wr_arg_o,
  output logic              rd_res_o,
  output logic              rd_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    sel_o = SEL_NONE;
    if (aligned) begin
      if (idx == IDX_W'(0))      sel_o = SEL_CTRL;
      else if (idx == IDX_W'(1)) sel_o = SEL_ARG;
      else if (idx == IDX_W'(2)) sel_o = SEL_RES;
    end
  end

  assign rd_o      = req_i && !we_i;
  assign wr_ctrl_o = req_i && we_i && (sel_o == SEL_CTRL);
  assign wr_arg_o  = req_i && we_i && (sel_o == SEL_ARG);
  assign rd_res_o  = rd_o && (sel_o == SEL_RES);
endmodule

// File: rtl/cop_fe_ctrl_reg.sv
module cop_fe_ctrl_reg
  import cop_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  // only named fields are stored; ready and reserved bits drop out in unpack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (wr_i) ctrl_q <= unpack_ctrl(wdata_i);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/cop_fe_result_seq.sv
module cop_fe_result_seq
  import cop_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_primary_i,
  input  logic [DATA_W-1:0] res_secondary_i,
  input  logic              rd_i,
  input  logic              res_size_i,
  input  logic              nres_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] view_o
);
  logic [DATA_W-1:0] pri_q, sec_q, last_q;
  logic              rdy_q, ptr_q;
  logic              take, last_step;

  assign take      = rd_i && rdy_q;
  assign last_step = res_size_i || !nres_i || ptr_q;

  always_comb begin
    if (!rdy_q)          view_o = last_q;
    else if (res_size_i) view_o = {sec_q[HALF_W-1:0], pri_q[HALF_W-1:0]};
    else if (ptr_q)      view_o = sec_q;
    else                 view_o = pri_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= '0;
      sec_q <= '0;
      rdy_q <= 1'b0;
      ptr_q <= 1'b0;
    end else if (res_valid_i) begin
      pri_q <= res_primary_i;
      sec_q <= res_secondary_i;
      rdy_q <= 1'b1;
      ptr_q <= 1'b0;
    end else if (take) begin
      if (last_step) begin
        rdy_q <= 1'b0;
        ptr_q <= 1'b0;
      end else begin
        ptr_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_q <= '0;
    else if (take) last_q <= view_o;
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/cop_result_frontend.sv
module cop_result_frontend
  import cop_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              res_valid_i,
  input  logic [31:0]       res_primary_i,
  input  logic [31:0]       res_secondary_i,
  output logic              arg_valid_o,
  output logic [31:0]       arg_data_o,
  output logic              irq_o,
  output logic              dma_rd_req_o
);
  reg_sel_e          sel;
  logic              wr_ctrl, wr_arg, rd_res, rd;
  ctrl_t             ctrl;
  logic              rdy;
  logic              res_size_w, nres_w;
  logic [DATA_W-1:0] res_view;

  cop_fe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .sel_o    (sel),
    .wr_ctrl_o(wr_ctrl),
    .wr_arg_o (wr_arg),
    .rd_res_o (rd_res),
    .rd_o     (rd)
  );

  cop_fe_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_ctrl),
    .wdata_i(wdata_i),
    .ctrl_o (ctrl)
  );

  assign res_size_w = ctrl.res_size;
  assign nres_w     = ctrl.nres;

  cop_fe_result_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .res_valid_i    (res_valid_i),
    .res_primary_i  (res_primary_i),
    .res_secondary_i(res_secondary_i),
    .rd_i           (rd_res),
    .res_size_i     (res_size_w),
    .nres_i         (nres_w),
    .rdy_o          (rdy),
    .view_o         (res_view)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_CTRL: rdata_o = pack_ctrl(ctrl, rdy);
        SEL_RES:  rdata_o = res_view;
        default:  rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_valid_o <= 1'b0;
      arg_data_o  <= '0;
    end else begin
      arg_valid_o <= wr_arg;
      if (wr_arg) arg_data_o <= wdata_i;
    end
  end

  assign irq_o        = rdy && ctrl.irq_en;
  assign dma_rd_req_o = rdy && ctrl.dma_rd_en;
endmodule

// File: rtl/cop_fe_checks.sv
module cop_fe_checks #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              res_valid_i,
  input logic              arg_valid_o,
  input logic [31:0]       arg_data_o,
  input logic              irq_o,
  input logic              dma_rd_req_o,
  input logic              rdy,
  input logic              res_size_w,
  input logic              nres_w
);
  logic rd_res, rd_ctrl, wr_arg;
  assign rd_res  = req_i && !we_i && (addr_i == ADDR_W'(8));
  assign rd_ctrl = req_i && !we_i && (addr_i == ADDR_W'(0));
  assign wr_arg  = req_i && we_i && (addr_i == ADDR_W'(4));

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl |-> ((rdata_o & ~32'h807F_07FF) == 32'h0));

  assert_post_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> rdy);

  assert_rise_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy) |-> $past(res_valid_i));

  assert_single_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_res && rdy && !res_size_w && !nres_w && !res_valid_i) |=> !rdy);

  assert_packed_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_res && rdy && res_size_w && !res_valid_i) |=> !rdy);

  assert_idle_stays_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy && !res_valid_i) |=> !rdy);

  assert_arg_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_arg |=> (arg_valid_o && (arg_data_o == $past(wdata_i))));

  assert_arg_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_arg |=> !arg_valid_o);

  assert_req_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || dma_rd_req_o) |-> rdy);
endmodule

bind cop_result_frontend cop_fe_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .res_valid_i (res_valid_i),
  .arg_valid_o (arg_valid_o),
  .arg_data_o  (arg_data_o),
  .irq_o       (irq_o),
  .dma_rd_req_o(dma_rd_req_o),
  .rdy         (rdy),
  .res_size_w  (res_size_w),
  .nres_w      (nres_w)
);

// File: tb/cop_result_frontend_tb.sv
module cop_result_frontend_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              res_valid = 1'b0;
  logic [31:0]       res_pri = '0, res_sec = '0;
  logic              arg_valid;
  logic [31:0]       arg_data;
  logic              irq, dma_rd;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cop_result_frontend #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .res_valid_i(res_valid),
    .res_primary_i(res_pri), .res_secondary_i(res_sec),
    .arg_valid_o(arg_valid), .arg_data_o(arg_data),
    .irq_o(irq), .dma_rd_req_o(dma_rd)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic post(input logic [31:0] p, input logic [31:0] s);
    @(negedge clk);
    res_valid = 1'b1; res_pri = p; res_sec = s;
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  function automatic logic [31:0] cfg(input int rs, input int nr);
    return (32'(rs) << 21) | (32'(nr) << 19) | 32'h0003_0050;
  endfunction

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, p, s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    bus_rd(4'h0, d); check("R2 reset ctrl", d, 32'h0000_0050);
    bus_rd(4'h8, d); check("R8 reset result", d, 32'h0);
    check("R11 reset irq", {31'b0, irq}, 32'h0);
    check("R10 reset strobe", {31'b0, arg_valid}, 32'h0);

    // field writability
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, d); check("R3 write ones", d, 32'h007F_07FF);
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h0, d); check("R2 write zeros", d, 32'h0);

    // decode
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'h0, d); check("R1 unmapped write", d, 32'h0);
    bus_rd(4'hC, d); check("R1 unmapped read", d, 32'h0);
    bus_wr(4'h1, 32'h0000_0123);
    bus_rd(4'h0, d); check("R1 misaligned write", d, 32'h0);
    bus_rd(4'h4, d); check("R1 arg reads zero", d, 32'h0);

    // argument strobe
    bus_wr(4'h4, 32'hA5A5_1234);
    check("R10 strobe high", {31'b0, arg_valid}, 32'h1);
    check("R10 strobe data", arg_data, 32'hA5A5_1234);
    @(posedge clk); #1;
    check("R10 strobe low", {31'b0, arg_valid}, 32'h0);

    // sweep of format and count
    for (int rs = 0; rs < 2; rs++) begin
      for (int nr = 0; nr < 2; nr++) begin
        for (int k = 0; k < 4; k++) begin
          p = 32'h1357_9BDF * (k + 1) + 32'(rs * 7 + nr);
          s = ~p ^ (32'h0F0F_0F0F << k);
          bus_wr(4'h0, cfg(rs, nr));
          post(p, s);
          bus_rd(4'h0, d); check("R4 ready after post", d[31] ? 32'h1 : 32'h0, 32'h1);
          check("R11 irq set", {31'b0, irq}, 32'h1);
          check("R11 dma set", {31'b0, dma_rd}, 32'h1);
          if (rs == 1) begin
            bus_rd(4'h8, d); check("R7 packed", d, {s[15:0], p[15:0]});
            bus_rd(4'h0, d); check("R7 cleared", {31'b0, d[31]}, 32'h0);
            p = {s[15:0], p[15:0]};
          end else if (nr == 1) begin
            bus_rd(4'h8, d); check("R5 first", d, p);
            bus_rd(4'h0, d); check("R5 still ready", {31'b0, d[31]}, 32'h1);
            bus_rd(4'h8, d); check("R5 second", d, s);
            bus_rd(4'h0, d); check("R5 cleared", {31'b0, d[31]}, 32'h0);
            p = s;
          end else begin
            bus_rd(4'h8, d); check("R6 single", d, p);
            bus_rd(4'h0, d); check("R6 cleared", {31'b0, d[31]}, 32'h0);
          end
          bus_rd(4'h8, d); check("R8 idle read", d, p);
          bus_rd(4'h0, d); check("R8 idle no set", {31'b0, d[31]}, 32'h0);
          check("R11 irq clear", {31'b0, irq}, 32'h0);
          check("R11 dma clear", {31'b0, dma_rd}, 32'h0);
        end
      end
    end

    // enables gate the requests
    bus_wr(4'h0, 32'h0000_0050);
    post(32'h1, 32'h2);
    check("R11 irq gated", {31'b0, irq}, 32'h0);
    check("R11 dma gated", {31'b0, dma_rd}, 32'h0);
    bus_rd(4'h8, d); check("R6 gated read", d, 32'h1);

    // result port is read-only; ready is not writable
    bus_wr(4'h0, cfg(0, 1));
    post(32'hCAFE_0001, 32'hBEEF_0002);
    bus_wr(4'h8, 32'hDEAD_DEAD);
    bus_wr(4'h0, cfg(0, 1) & 32'h7FFF_FFFF);
    bus_rd(4'h0, d); check("R3 ready kept", {31'b0, d[31]}, 32'h1);
    bus_rd(4'h8, d); check("R9 write ignored", d, 32'hCAFE_0001);

    // new post mid-sequence restarts at primary
    post(32'h1111_AAAA, 32'h2222_BBBB);
    bus_rd(4'h8, d); check("R4 restart primary", d, 32'h1111_AAAA);
    bus_rd(4'h8, d); check("R4 restart secondary", d, 32'h2222_BBBB);
    bus_wr(4'h0, 32'h8000_0000 | cfg(0, 1));
    bus_rd(4'h0, d); check("R3 ready not settable", d, cfg(0, 1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule